// File: doc/BRIEF.md
# Chip-Rate Phase Accumulator with Write-Addressed Registers

This block sets the chip timing of a spreading-code receiver. A small bank of four 32-bit registers is written over a simple strobe bus. Two registers hold the chip-rate frequency word and a start phase. Two more hold tap-select words, which pass straight out to a neighbouring code generator. A modulo accumulator adds the frequency word on every valid input sample. Each time the running sum reaches the decimal modulus 100,000,000, the accumulator wraps and raises a one-cycle chip-advance pulse. That pulse tells the code generator to step to its next chip.

A sync input reloads the accumulator from the phase register, so the code timing can be realigned to a known offset. The bus data word is echoed unchanged on a data output, so the bus can be daisy-chained past the block.

Top module: `chip_rate_acc`

## Requirements
- R1: While rst_ni is low, acc_o, chip_adv_o, tap_a_o and tap_b_o are zero, and so are the internal frequency and phase registers.
- R2: On a clock edge with wr_stb_i high, the word on wr_data_i is stored at the addressed register: address 0 is frequency, 4 is phase, 8 is tap A (tap_a_o) and 12 is tap B (tap_b_o). The new value is in effect from the next cycle.
- R3: A write to any other address, or any cycle with wr_stb_i low, changes no register.
- R4: With sync_i high at an edge, acc_o takes the phase register value on that edge and chip_adv_o is low. Sync wins over a sample arriving in the same cycle.
- R5: With both sync_i and smp_vld_i low at an edge, acc_o holds its value.
- R6: With smp_vld_i high and sync_i low at an edge, acc_o becomes acc_o + frequency. If that sum is at least 100,000,000, it becomes the sum minus 100,000,000 and chip_adv_o is high for the following cycle only.
- R7: chip_adv_o is high only in the cycle after a cycle with smp_vld_i high and sync_i low.
- R8: data_o equals wr_data_i in the same cycle.
- R9: The sum is formed one bit wider than the data path, so a frequency word up to 2^32-1 loses no carry before the wrap compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 32 | Register write data |
| wr_addr_i | input | 4 | Register write address |
| wr_stb_i | input | 1 | Write strobe |
| sync_i | input | 1 | Reload accumulator from phase |
| smp_vld_i | input | 1 | Sample valid, advances the accumulator |
| data_o | output | 32 | Echo of wr_data_i |
| acc_o | output | 32 | Accumulator value |
| chip_adv_o | output | 1 | One-cycle chip-advance pulse |
| tap_a_o | output | 32 | Tap-select word A |
| tap_b_o | output | 32 | Tap-select word B |

## Verification
The data echo has no register, so it is checked one time unit after the inputs change, within the same cycle. Every other result is due one clock after the edge that samples its cause. This covers a register write, a sync reload, an accumulate with or without a wrap, and the chip-advance pulse.

The bench drives its inputs at the falling edge and steps a reference model at the rising edge, using the register values from before that edge. It compares every output at the next falling edge. The tests include a write and a sync in the same cycle, a sync together with a sample, and a near-maximum frequency word. These show whether a write takes effect one cycle late.

// File: rtl/chip_acc_pkg.sv
package chip_acc_pkg;
  parameter int unsigned DW       = 32;
  parameter int unsigned AW       = 4;
  parameter int unsigned NUM_REGS = 4;
  parameter int unsigned MODULUS  = 100_000_000;

  // register index = address / 4
  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_TAP_A = 2'd2,
    SEL_TAP_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/chip_acc_regs.sv
module chip_acc_regs #(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 4,
  parameter int unsigned NREG = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic                     wr_stb_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  localparam int unsigned STRIDE = 4;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_stb_i && (wr_addr_i == AW'(g * STRIDE));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[g] <= '0;
      else if (hit) regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/chip_acc_core.sv
module chip_acc_core #(
  parameter int unsigned DW  = 32,
  parameter int unsigned MOD = 100_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] freq_i,
  input  logic [DW-1:0] phase_i,
  output logic [DW-1:0] acc_o,
  output logic          adv_o
);
  localparam int unsigned SW = DW + 1;
  localparam logic [SW-1:0] MOD_W = SW'(MOD);

  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;
  logic          wrap;

  // one extra bit keeps the carry until the compare
  assign sum     = {1'b0, acc_o} + {1'b0, freq_i};
  assign wrap    = (sum >= MOD_W);
  assign wrapped = sum - MOD_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      adv_o <= 1'b0;
    end else if (sync_i) begin
      acc_o <= phase_i;
      adv_o <= 1'b0;
    end else if (smp_vld_i) begin
      acc_o <= wrap ? wrapped[DW-1:0] : sum[DW-1:0];
      adv_o <= wrap;
    end else begin
      adv_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chip_rate_acc.sv
module chip_rate_acc
  import chip_acc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   wr_data_i,
  input  logic [3:0]    wr_addr_i,
  input  logic          wr_stb_i,
  input  logic          sync_i,
  input  logic          smp_vld_i,
  output logic [31:0]   data_o,
  output logic [31:0]   acc_o,
  output logic          chip_adv_o,
  output logic [31:0]   tap_a_o,
  output logic [31:0]   tap_b_o
);
  logic [NUM_REGS-1:0][DW-1:0] regs;
  logic [DW-1:0] freq_q;
  logic [DW-1:0] phase_q;

  chip_acc_regs #(.DW(DW), .AW(AW), .NREG(NUM_REGS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (wr_data_i),
    .wr_addr_i (wr_addr_i),
    .wr_stb_i  (wr_stb_i),
    .regs_o    (regs)
  );

  assign freq_q  = regs[SEL_FREQ];
  assign phase_q = regs[SEL_PHASE];
  assign tap_a_o = regs[SEL_TAP_A];
  assign tap_b_o = regs[SEL_TAP_B];

  chip_acc_core #(.DW(DW), .MOD(MODULUS)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .smp_vld_i (smp_vld_i),
    .freq_i    (freq_q),
    .phase_i   (phase_q),
    .acc_o     (acc_o),
    .adv_o     (chip_adv_o)
  );

  assign data_o = wr_data_i;
endmodule

// File: rtl/chip_acc_chk.sv
module chip_acc_chk #(
  parameter int unsigned MOD = 100_000_000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  wr_addr_i,
  input logic        wr_stb_i,
  input logic        sync_i,
  input logic        smp_vld_i,
  input logic [31:0] acc_o,
  input logic        chip_adv_o,
  input logic [31:0] tap_a_o,
  input logic [31:0] tap_b_o,
  input logic [31:0] freq_q,
  input logic [31:0] phase_q
);
  AST_SYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (acc_o == $past(phase_q)) && !chip_adv_o); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !smp_vld_i) |=> $stable(acc_o) && !chip_adv_o); // R5

  AST_STAY_BELOW_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && smp_vld_i && acc_o < MOD && freq_q < MOD) |=> acc_o < MOD); // R6

  AST_ADV_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_adv_o |-> $past(smp_vld_i) && !$past(sync_i)); // R7

  AST_UNUSED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_addr_i[1:0] != 2'b00) |=> $stable(tap_a_o) && $stable(tap_b_o)); // R3

  AST_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(tap_a_o) && $stable(tap_b_o)); // R3
endmodule

bind chip_rate_acc chip_acc_chk #(.MOD(chip_acc_pkg::MODULUS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_addr_i  (wr_addr_i),
  .wr_stb_i   (wr_stb_i),
  .sync_i     (sync_i),
  .smp_vld_i  (smp_vld_i),
  .acc_o      (acc_o),
  .chip_adv_o (chip_adv_o),
  .tap_a_o    (tap_a_o),
  .tap_b_o    (tap_b_o),
  .freq_q     (freq_q),
  .phase_q    (phase_q)
);

// File: tb/sim_chip_rate_acc.sv
`timescale 1ns/1ps
module sim_chip_rate_acc;
  localparam longint unsigned MODV = 100_000_000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  wr_addr_i = '0;
  logic        wr_stb_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        smp_vld_i = 1'b0;
  logic [31:0] data_o, acc_o, tap_a_o, tap_b_o;
  logic        chip_adv_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  longint unsigned m_freq, m_phase, m_ta, m_tb, m_acc;
  bit m_adv;

  always #4 clk_i = ~clk_i;

  chip_rate_acc u0 (.*);

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, step model at posedge, compare at next negedge
  task automatic step(bit stb, logic [3:0] addr, logic [31:0] data, bit syn, bit vld);
    longint unsigned sum;
    string tg_acc, tg_adv, tg_reg;
    wr_stb_i = stb; wr_addr_i = addr; wr_data_i = data; sync_i = syn; smp_vld_i = vld;
    #1 chk("R8", "data_o", data_o, data);
    @(posedge clk_i);
    if (syn) begin
      m_acc = m_phase; m_adv = 0;
    end else if (vld) begin
      sum = m_acc + m_freq;
      if (sum >= MODV) begin sum = sum - MODV; m_adv = 1; end
      else m_adv = 0;
      m_acc = sum & 64'hFFFF_FFFF;
    end else m_adv = 0;
    if (stb) case (addr)
      4'd0:  m_freq  = data;
      4'd4:  m_phase = data;
      4'd8:  m_ta    = data;
      4'd12: m_tb    = data;
      default: ;
    endcase
    tg_acc = syn ? "R4" : (vld ? "R6" : "R5");
    tg_adv = syn ? "R4" : (vld ? "R6" : "R7");
    tg_reg = (stb && addr[1:0] == 2'b00) ? "R2" : "R3";
    @(negedge clk_i);
    chk(tg_acc, "acc_o", acc_o, m_acc);
    chk(tg_adv, "chip_adv_o", chip_adv_o, m_adv);
    chk(tg_reg, "tap_a_o", tap_a_o, m_ta);
    chk(tg_reg, "tap_b_o", tap_b_o, m_tb);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_freq = 0; m_phase = 0; m_ta = 0; m_tb = 0; m_acc = 0; m_adv = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "acc_o", acc_o, 0);
    chk("R1", "chip_adv_o", chip_adv_o, 0);
    chk("R1", "tap_a_o", tap_a_o, 0);
    chk("R1", "tap_b_o", tap_b_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(0, 4'd0, 32'h0, 0, 1);          // R1: zero freq, no advance
    step(1, 4'd0, 30_000_000, 0, 0);
    step(1, 4'd4, 12_345, 0, 0);
    step(1, 4'd8, 32'h0000_0204, 0, 0);
    step(1, 4'd12, 32'h0000_03A6, 0, 0);
    // R3 unused addresses and strobe low
    step(1, 4'd2, 32'hDEAD_BEEF, 0, 0);
    step(1, 4'd9, 32'hDEAD_BEEF, 0, 0);
    step(1, 4'd15, 32'hDEAD_BEEF, 0, 0);
    step(0, 4'd8, 32'hCAFE_F00D, 0, 0);
    step(0, 4'd4, 32'hCAFE_F00D, 1, 0);  // phase unchanged, R4 reload
    for (int i = 0; i < 12; i++) step(0, 4'd0, i, 0, 1);
    step(0, 4'd0, 0, 0, 0);
    step(0, 4'd0, 0, 0, 0);
    step(0, 4'd0, 0, 1, 1);              // R4 sync beats sample
    step(1, 4'd4, 77, 1, 0);             // write and sync same edge: old phase
    step(0, 4'd0, 0, 1, 0);              // new phase now
    step(1, 4'd0, 99_999_999, 0, 1);
    for (int i = 0; i < 6; i++) step(0, 4'd0, 0, 0, 1);
    // R9 near-maximum frequency word
    step(1, 4'd4, 99_999_999, 0, 0);
    step(1, 4'd0, 32'hFFFF_FFFF, 1, 0);
    step(0, 4'd0, 0, 0, 1);
    step(1, 4'd0, 25_000_000, 1, 0);
    for (int i = 0; i < 2000; i++) begin
      bit s = ($urandom_range(0, 3) == 0);
      logic [3:0] a = 4'($urandom_range(0, 15));
      logic [31:0] d = (a == 4'd0 || a == 4'd4) ? 32'($urandom_range(0, 99_999_999)) : $urandom;
      step(s, a, d, ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) != 0));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule